// File: doc/BRIEF.md
# Routed Interrupt Controller

This block collects 32 interrupt requests and steers each one to one or more interrupt lines of one or more processor cores. Each source has its own trigger mode and polarity. In level mode the source is pending while its input is at the active level. In edge mode the source catches the chosen transition in a sticky bit that software clears. An enable mask gates every source before it reaches any output. The mask is changed through separate set and clear strobes, so software never needs a read-modify-write to change it.

Software reaches the block through a plain 32-bit register bus. A write happens in the cycle in which `bus_wr` is high. Reads are combinational on `bus_addr`. Each source has its own route byte. The upper nibble is a one-hot (or multi-hot) choice among four output lines, and the lower nibble makes the same choice among four cores. There are 4 lines for each of 4 cores, giving 16 outputs. Each core also has a read-only view of the enabled pending sources routed to it.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the enable mask (read at 0x24) is 0, the edge-mode register (0x34) is 0, so every source is level-triggered, the polarity register (0x30) is 0xFFFFFFFF, every route byte is 0, and all of `irq_o` is 0.
- R2: A write to 0x28 sets each enable bit whose data bit is 1 and leaves bits written with 0 unchanged. The mask reads back at 0x24.
- R3: A write to 0x2C clears each enable bit whose data bit is 1, and 0xFFFFFFFF clears them all. A disabled source drops off `irq_o` at once.
- R4: The route byte of source n sits at byte offset n (0x00 to 0x1F), in lane n%4 of the word at n&~3. A write there updates only the lanes whose `bus_be` bit is 1, and a read of the word returns all four bytes. Byte enables have no effect at any other offset.
- R5: In level mode (edge bit 0) a source is pending while its synchronised input equals its polarity bit (1 means active-high, 0 means active-low). After an input change, the pending state changes following the second rising clock edge.
- R6: In edge mode (edge bit 1) a rising edge (polarity 1) or a falling edge (polarity 0) sets a sticky pending bit on the third clock edge after the input change. The bit stays set until a write to 0x40 with a 1 in that bit position. An edge that arrives together with the clear wins. Clearing the edge bit drops the sticky bit.
- R7: A read of 0x40 returns the pending sources that are also enabled.
- R8: `irq_o[c*4+i]` is the OR of every enabled pending source whose route byte has bit 4+i and bit c set. A route byte with several bits set in a nibble drives every selected line and core.
- R9: A read of 0x50+4*c returns the enabled pending sources whose route byte has bit c set.
- R10: A read of any other offset returns 0. This includes the write-only strobes 0x28 and 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt inputs, asynchronous |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables, used by route-table writes only |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 16 | Output lines, bit c*4+i is line i of core c |

## Verification
The assertions assume that reset is held low for at least one clock edge before any bus traffic, and that every bus write is a single-cycle strobe with stable address and data around the edge. They also take any interrupt input as asynchronous, so they reason only about values after the two synchronising flops. The stimulus changes inputs and bus fields only at falling clock edges. It holds every edge-mode pulse for at least one full clock so that the synchroniser sees it, and it arms edge mode only while the inputs are quiet, so that no edge is caught while the mode changes.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Level view of a synchronised input: polarity 1 is active-high.
  function automatic logic level_active(input logic smp, input logic pol);
    return pol ? smp : ~smp;
  endfunction

  // Transition of the chosen direction between the previous and current sample.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Sticky edge bit update: an edge beats a clear, leaving edge mode empties it.
  function automatic logic sticky_next(input logic edge_mode, input logic held,
                                       input logic clr, input logic hit);
    return edge_mode ? ((held & ~clr) | hit) : 1'b0;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic pend_o
);

  logic sync_a, sync_b, sync_prev;
  logic sticky_q;
  logic edge_det;   // named event for the checks below

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync_a    <= raw_i;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  assign edge_det = edge_hit(sync_b, sync_prev, pol_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_next(edge_i, sticky_q, clr_i, edge_det);
  end

  assign pend_o = edge_i ? sticky_q : level_active(sync_b, pol_i);

  // R6: a detected edge in edge mode is caught on the next clock
  p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && edge_det) |=> sticky_q);

  // R6: a caught edge is held until software writes a one to clear it
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && sticky_q && !clr_i) |=> sticky_q);

  // R5: in level mode nothing is left in the sticky store
  p_level_no_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_i) |=> !sticky_q);

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int N_SRC  = 32,
  parameter int N_LINE = 4,
  parameter int N_CORE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SRC-1:0]           active_i,
  input  logic [N_SRC*(N_LINE+N_CORE)-1:0] route_i,
  output logic [N_CORE*N_LINE-1:0]   irq_o,
  output logic [N_CORE*N_SRC-1:0]    core_pend_o
);

  localparam int RW = N_LINE + N_CORE;

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign core_pend_o[c*N_SRC + s] = active_i[s] & route_i[s*RW + c];
    end

    for (genvar i = 0; i < N_LINE; i++) begin : g_line
      logic [N_SRC-1:0] line_sel;
      for (genvar s = 0; s < N_SRC; s++) begin : g_pick
        assign line_sel[s] = core_pend_o[c*N_SRC + s] & route_i[s*RW + N_CORE + i];
      end
      assign irq_o[c*N_LINE + i] = |line_sel;

      // R8: a raised line always has a source in its core's pending view
      p_line_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c*N_LINE + i] |-> (core_pend_o[c*N_SRC +: N_SRC] != '0));
    end

    // R9: a core view never shows a source that is not active
    p_core_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (core_pend_o[c*N_SRC +: N_SRC] & ~active_i) == '0);
  end

  // R8: with no active source every output is low
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i == '0) |-> (irq_o == '0));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_LINE = 4,
  parameter int N_CORE = 4,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         irq_in,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic [3:0]               bus_be,
  output logic [31:0]              bus_rdata,
  output logic [N_CORE*N_LINE-1:0] irq_o
);

  localparam int RW       = N_LINE + N_CORE;
  localparam int RT_WORDS = (N_SRC + 3) / 4;
  localparam logic [ADDR_W-1:0] OFS_RT_END = ADDR_W'(RT_WORDS * 4);
  localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] OFS_SET    = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFS_CLR    = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] OFS_POL    = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFS_EDGE   = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] OFS_STAT   = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] OFS_CORE0  = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] OFS_CORE_END = ADDR_W'(8'h50 + 4 * N_CORE);

  logic [N_SRC-1:0] en_q, pol_q, edge_q;
  logic [RW-1:0]    route_q [N_SRC];
  logic [N_SRC*RW-1:0] route_flat;
  logic [N_SRC-1:0] pend, active, clr_vec;
  logic [N_CORE*N_SRC-1:0] core_pend;

  logic wr_route, wr_set, wr_clr, wr_pol, wr_edge, wr_stat;
  assign wr_route = bus_wr && (bus_addr < OFS_RT_END);
  assign wr_set   = bus_wr && (bus_addr == OFS_SET);
  assign wr_clr   = bus_wr && (bus_addr == OFS_CLR);
  assign wr_pol   = bus_wr && (bus_addr == OFS_POL);
  assign wr_edge  = bus_wr && (bus_addr == OFS_EDGE);
  assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
  assign clr_vec  = wr_stat ? bus_wdata[N_SRC-1:0] : '0;

  // Enable mask: set and clear strobes, set applied before clear in priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_set) en_q <= en_q | bus_wdata[N_SRC-1:0];
    else if (wr_clr) en_q <= en_q & ~bus_wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '1;
      edge_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= bus_wdata[N_SRC-1:0];
      if (wr_edge) edge_q <= bus_wdata[N_SRC-1:0];
    end
  end

  // Route table: one byte per source, byte lanes honoured
  for (genvar n = 0; n < N_SRC; n++) begin : g_route
    localparam int WORD = n / 4;
    localparam int LANE = n % 4;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_q[n] <= '0;
      else if (wr_route && (int'(bus_addr[ADDR_W-1:2]) == WORD) && bus_be[LANE])
        route_q[n] <= bus_wdata[8*LANE +: RW];
    end
    assign route_flat[n*RW +: RW] = route_q[n];
  end

  // Per-source front end: synchroniser, edge catch, level view
  for (genvar n = 0; n < N_SRC; n++) begin : g_cell
    irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (irq_in[n]),
      .pol_i  (pol_q[n]),
      .edge_i (edge_q[n]),
      .clr_i  (clr_vec[n]),
      .pend_o (pend[n])
    );
  end

  assign active = pend & en_q;

  irq_route_matrix #(
    .N_SRC  (N_SRC),
    .N_LINE (N_LINE),
    .N_CORE (N_CORE)
  ) u_matrix (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .route_i     (route_flat),
    .irq_o       (irq_o),
    .core_pend_o (core_pend)
  );

  // Read mux
  always_comb begin
    int word_idx;
    int src_idx;
    int core_idx;
    bus_rdata = '0;
    word_idx  = int'(bus_addr[ADDR_W-1:2]);
    core_idx  = int'((bus_addr - OFS_CORE0) >> 2);
    if (bus_addr < OFS_RT_END) begin
      for (int k = 0; k < 4; k++) begin
        src_idx = word_idx * 4 + k;
        if (src_idx < N_SRC) bus_rdata[8*k +: RW] = route_flat[src_idx*RW +: RW];
      end
    end else if ((bus_addr >= OFS_CORE0) && (bus_addr < OFS_CORE_END) &&
                 (bus_addr[1:0] == 2'b00)) begin
      bus_rdata[N_SRC-1:0] = core_pend[core_idx*N_SRC +: N_SRC];
    end else begin
      case (bus_addr)
        OFS_MASK: bus_rdata[N_SRC-1:0] = en_q;
        OFS_POL:  bus_rdata[N_SRC-1:0] = pol_q;
        OFS_EDGE: bus_rdata[N_SRC-1:0] = edge_q;
        OFS_STAT: bus_rdata[N_SRC-1:0] = active;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2: every bit written as one to the set strobe is enabled afterwards
  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  // R3: an all-ones clear strobe leaves nothing enabled
  p_disable_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && (&bus_wdata[N_SRC-1:0])) |=> (en_q == '0));

  // R3: a clear strobe never enables anything new
  p_clear_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & ~$past(en_q)) == '0));

endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_route_ctrl u_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_en, m_pol, m_edge, m_sticky;
  logic [7:0]  m_route [32];
  logic [31:0] hist [$];   // hist[0] newest sample of irq_in

  task automatic m_reset();
    m_en = 0; m_pol = 32'hFFFF_FFFF; m_edge = 0; m_sticky = 0;
    for (int s = 0; s < 32; s++) m_route[s] = 8'h00;
    hist = {32'h0, 32'h0, 32'h0};
  endtask

  function automatic logic [31:0] m_pending();
    logic [31:0] p;
    for (int s = 0; s < 32; s++)
      p[s] = m_edge[s] ? m_sticky[s] : (hist[1][s] == m_pol[s]);
    return p;
  endfunction

  function automatic logic [31:0] m_core(int c);
    logic [31:0] a, r;
    a = m_pending() & m_en;
    r = 0;
    for (int s = 0; s < 32; s++) r[s] = a[s] && m_route[s][c];
    return r;
  endfunction

  function automatic logic [15:0] m_out();
    logic [15:0] o;
    o = 0;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 4; i++)
        for (int s = 0; s < 32; s++)
          if (m_core(c)[s] && m_route[s][4+i]) o[c*4+i] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a < 8'h20) begin
      int w = a / 4;
      return {m_route[w*4+3], m_route[w*4+2], m_route[w*4+1], m_route[w*4]};
    end
    case (a)
      8'h24: return m_en;
      8'h30: return m_pol;
      8'h34: return m_edge;
      8'h40: return m_pending() & m_en;
      8'h50: return m_core(0);
      8'h54: return m_core(1);
      8'h58: return m_core(2);
      8'h5C: return m_core(3);
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_step();
    logic [31:0] nst;
    for (int s = 0; s < 32; s++) begin
      logic up, dn, hit, clr;
      up  = hist[1][s] && !hist[2][s];
      dn  = !hist[1][s] && hist[2][s];
      hit = m_pol[s] ? up : dn;
      clr = bus_wr && (bus_addr == 8'h40) && bus_wdata[s];
      if (!m_edge[s]) nst[s] = 1'b0;
      else if (hit)   nst[s] = 1'b1;
      else            nst[s] = m_sticky[s] && !clr;
    end
    if (bus_wr) begin
      if (bus_addr < 8'h20) begin
        for (int k = 0; k < 4; k++)
          if (bus_be[k]) m_route[(bus_addr / 4) * 4 + k] = bus_wdata[8*k +: 8];
      end else begin
        case (bus_addr)
          8'h28: m_en = m_en | bus_wdata;
          8'h2C: m_en = m_en & ~bus_wdata;
          8'h30: m_pol = bus_wdata;
          8'h34: m_edge = bus_wdata;
          default: ;
        endcase
      end
    end
    m_sticky = nst;
    hist.push_front(irq_in);
    void'(hist.pop_back());
  endtask

  function automatic string region_tag(logic [7:0] a);
    if (a < 8'h20) return "R4";
    if (a == 8'h24) return "R2";
    if (a == 8'h30) return "R5";
    if (a == 8'h34) return "R6";
    if (a == 8'h40) return "R7";
    if (a >= 8'h50 && a <= 8'h5C && a[1:0] == 0) return "R9";
    return "R10";
  endfunction

  initial m_reset();

  // Model step and every-cycle comparison
  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
    #2;
    checks++;
    if (irq_o !== m_out()) begin
      failures++;
      $display("FAIL model R8 irq_o act=%h exp=%h t=%0t", irq_o, m_out(), $time);
    end
    checks++;
    if (bus_rdata !== m_read(bus_addr)) begin
      failures++;
      $display("FAIL model %s read addr=%h act=%h exp=%h t=%0t",
               region_tag(bus_addr), bus_addr, bus_rdata, m_read(bus_addr), $time);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic out_chk(logic [15:0] exp, string tag);
    @(negedge clk);
    #1;
    chk(tag, {16'h0, irq_o}, {16'h0, exp});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic set_raw(logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    rd_chk(8'h24, 32'h0, "R1 enable mask");
    rd_chk(8'h34, 32'h0, "R1 edge mode");
    rd_chk(8'h30, 32'hFFFF_FFFF, "R1 polarity");
    rd_chk(8'h00, 32'h0, "R1 route word");
    out_chk(16'h0, "R1 outputs");

    // R4 route table with byte lanes
    wr(8'h00, 32'h3824_1211, 4'hF);
    wr(8'h00, 32'hFFFF_55FF, 4'h2);
    rd_chk(8'h00, 32'h3824_5511, "R4 lane write");
    wr(8'h04, 32'hAAAA_4881, 4'h3);
    rd_chk(8'h04, 32'h0000_4881, "R4 low lanes");

    // R2 enable set strobe, R10 strobe reads
    wr(8'h28, 32'h0000_000F, 4'hF);
    rd_chk(8'h24, 32'h0000_000F, "R2 set");
    wr(8'h28, 32'h0000_0100, 4'h0);
    rd_chk(8'h24, 32'h0000_010F, "R2 zeros keep");
    rd_chk(8'h28, 32'h0, "R10 set strobe read");
    rd_chk(8'h2C, 32'h0, "R10 clear strobe read");

    // R5 level timing, R7, R8, R9
    set_raw(32'h1);
    rd_chk(8'h40, 32'h0, "R5 one edge not yet");
    rd_chk(8'h40, 32'h1, "R5 second edge pending");
    out_chk(16'h0001, "R8 core0 line0");
    rd_chk(8'h50, 32'h1, "R9 core0 view");

    set_raw(32'h0B);
    tick(3);
    out_chk(16'h3505, "R8 fan-out");
    rd_chk(8'h58, 32'h2, "R9 core2 view");
    rd_chk(8'h5C, 32'h8, "R9 core3 view");
    rd_chk(8'h50, 32'h3, "R9 core0 two sources");

    set_raw(32'h1B);
    tick(3);
    rd_chk(8'h40, 32'h0B, "R7 disabled source hidden");

    wr(8'h30, 32'hFFFF_FFFE, 4'hF);
    tick(1);
    rd_chk(8'h40, 32'h0A, "R5 active-low idle");
    set_raw(32'h1A);
    tick(3);
    rd_chk(8'h40, 32'h0B, "R5 active-low asserted");

    // R3 clear strobe
    wr(8'h2C, 32'h0000_0002, 4'hF);
    rd_chk(8'h24, 32'h0000_010D, "R3 single clear");
    out_chk(16'h3001, "R3 output drop");
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    rd_chk(8'h24, 32'h0, "R3 clear all");
    out_chk(16'h0, "R3 outputs off");

    // R6 edge mode
    set_raw(32'h0);
    tick(4);
    wr(8'h30, 32'hFFFF_FFDF, 4'hF);
    wr(8'h34, 32'h0000_0030, 4'hF);
    wr(8'h28, 32'h0000_0030, 4'hF);
    rd_chk(8'h34, 32'h0000_0030, "R6 edge readback");
    set_raw(32'h20);
    tick(4);
    rd_chk(8'h40, 32'h0, "R6 rising ignored on falling source");
    set_raw(32'h30);
    set_raw(32'h20);
    tick(4);
    rd_chk(8'h40, 32'h10, "R6 pulse caught");
    out_chk(16'h0008, "R8 edge source core0 line3");
    wr(8'h40, 32'h10, 4'hF);
    rd_chk(8'h40, 32'h0, "R6 write-one clear");
    set_raw(32'h00);
    tick(4);
    rd_chk(8'h40, 32'h20, "R6 falling caught");
    out_chk(16'h4000, "R8 core3 line2");
    wr(8'h40, 32'h10, 4'hF);
    rd_chk(8'h40, 32'h20, "R6 zero bit keeps sticky");

    // R10 unmapped
    rd_chk(8'h38, 32'h0, "R10 hole 0x38");
    rd_chk(8'h44, 32'h0, "R10 hole 0x44");
    rd_chk(8'h60, 32'h0, "R10 hole 0x60");
    rd_chk(8'hFC, 32'h0, "R10 hole 0xFC");

    tick(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule